// File: doc/BRIEF.md
# Indexed Color Palette Register Port

This block is a 256-entry color lookup table that a host programs through four byte-wide registers. The host picks a starting entry in the write-index register and then streams color bytes through one data register. The bytes arrive as red, then green, then blue, and the write index advances by one after each complete triple. Readback works the same way, through a separate read-index register and the same data register. Each component is held at 6-bit precision, in the low six bits of the byte.

A pixel-side port runs alongside the host port without interference. Each cycle it takes an 8-bit pixel index, ANDs it with the pixel mask register, looks up the entry and presents the 18-bit color one cycle later. Pipelines that drive a converter or a pixel stream use it for indexed color depths.

Top module: `color_palette_port`

## Requirements
- R1: After reset, reading register 0 (write index) and register 1 (read index) returns 0, and reading register 3 (pixel mask) returns 0xFF. Every host read places its byte on host_rdata_o at the first rising edge after the read strobe.
- R2: Writing register 0 sets the entry that programming starts at and restarts the component order at red. A partial triple begun before that write is discarded.
- R3: Successive writes to register 2 (data) fill red, green and blue of the current write entry. The entry changes only when the blue byte is written, and is then {red,green,blue} with red in bits 17:12 and blue in bits 5:0.
- R4: Only bits 5:0 of each data byte are stored. Bits 7:6 are ignored on write and read back as zero from register 2.
- R5: The write index increments by one after each blue write and wraps modulo 256. After N complete triples from index 0, register 0 reads N mod 256.
- R6: Writing register 1 selects the readback entry and restarts the readback component order at red.
- R7: Successive reads of register 2 return red, green, then blue of the current read entry. The read index increments after blue and wraps modulo 256.
- R8: The pixel index is ANDed with the mask (written through register 3) before lookup. A mask of 0xFF passes every index unchanged.
- R9: pix_color_o shows the entry addressed in the previous cycle, independent of host traffic. When a blue write and a pixel lookup hit the same entry in the same cycle, the pixel port returns the old value and then the new value one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_we_i | input | 1 | Host register write strobe (wins over a read in the same cycle) |
| host_re_i | input | 1 | Host register read strobe |
| host_addr_i | input | 2 | Register select: 0 write index, 1 read index, 2 data, 3 pixel mask |
| host_wdata_i | input | 8 | Host write byte |
| host_rdata_o | output | 8 | Host read byte, registered |
| pix_idx_i | input | 8 | Pixel index for lookup |
| pix_color_o | output | 18 | Looked-up color {red,green,blue}, 6 bits each |

## Verification
The hardest case to reach is a blue write that commits an entry in the same cycle that the pixel port addresses that entry. The bench builds a partial triple on a chosen entry, then drives the blue byte and that pixel index on the same edge. It expects the old color first and the new color on the following cycle. Full 256-entry write and read sweeps drive both indices through their wrap. Pixel sweeps under several masks cover the aliasing that masking produces.

// File: rtl/cpal_pkg.sv
package cpal_pkg;
  typedef enum logic [1:0] {
    REG_WIDX = 2'd0,
    REG_RIDX = 2'd1,
    REG_DATA = 2'd2,
    REG_MASK = 2'd3
  } cpal_reg_e;

  typedef enum logic [1:0] {
    COMP_RED = 2'd0,
    COMP_GRN = 2'd1,
    COMP_BLU = 2'd2
  } cpal_comp_e;

  localparam int unsigned NUM_COMP = 3;
endpackage

// File: rtl/cpal_seq.sv
// Entry index with modulo-3 component sub-counter.
module cpal_seq
  import cpal_pkg::*;
#(
  parameter int unsigned IDX_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [IDX_W-1:0] load_val_i,
  input  logic             step_i,
  output logic [IDX_W-1:0] idx_o,
  output cpal_comp_e       comp_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_o  <= '0;
      comp_o <= COMP_RED;
    end else if (load_i) begin
      idx_o  <= load_val_i;
      comp_o <= COMP_RED;
    end else if (step_i) begin
      unique case (comp_o)
        COMP_RED: comp_o <= COMP_GRN;
        COMP_GRN: comp_o <= COMP_BLU;
        default: begin
          comp_o <= COMP_RED;
          idx_o  <= idx_o + 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/cpal_store.sv
// Palette storage: one write port, two asynchronous read ports.
module cpal_store #(
  parameter int unsigned IDX_W   = 8,
  parameter int unsigned ENTRY_W = 18
) (
  input  logic               clk_i,
  input  logic               we_i,
  input  logic [IDX_W-1:0]   waddr_i,
  input  logic [ENTRY_W-1:0] wdata_i,
  input  logic [IDX_W-1:0]   host_raddr_i,
  output logic [ENTRY_W-1:0] host_rdata_o,
  input  logic [IDX_W-1:0]   pix_raddr_i,
  output logic [ENTRY_W-1:0] pix_rdata_o
);
  localparam int unsigned ENTRIES = 1 << IDX_W;

  logic [ENTRY_W-1:0] mem_q [ENTRIES];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign host_rdata_o = mem_q[host_raddr_i];
  assign pix_rdata_o  = mem_q[pix_raddr_i];
endmodule

// File: rtl/color_palette_port.sv
module color_palette_port
  import cpal_pkg::*;
#(
  parameter int unsigned BUS_W  = 8,
  parameter int unsigned COMP_W = 6
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     host_we_i,
  input  logic                     host_re_i,
  input  logic [1:0]               host_addr_i,
  input  logic [BUS_W-1:0]         host_wdata_i,
  output logic [BUS_W-1:0]         host_rdata_o,
  input  logic [BUS_W-1:0]         pix_idx_i,
  output logic [NUM_COMP*COMP_W-1:0] pix_color_o
);
  localparam int unsigned IDX_W   = BUS_W;
  localparam int unsigned ENTRY_W = NUM_COMP * COMP_W;
  localparam int unsigned PAD_W   = BUS_W - COMP_W;

  cpal_reg_e reg_sel;
  assign reg_sel = cpal_reg_e'(host_addr_i);

  logic rd_strobe;
  logic widx_load, ridx_load, data_wr, data_rd, mask_wr, commit;
  assign rd_strobe = host_re_i & ~host_we_i;
  assign widx_load = host_we_i & (reg_sel == REG_WIDX);
  assign ridx_load = host_we_i & (reg_sel == REG_RIDX);
  assign data_wr   = host_we_i & (reg_sel == REG_DATA);
  assign mask_wr   = host_we_i & (reg_sel == REG_MASK);
  assign data_rd   = rd_strobe & (reg_sel == REG_DATA);

  logic [IDX_W-1:0] wr_idx, rd_idx;
  cpal_comp_e       wr_comp, rd_comp;

  cpal_seq #(.IDX_W(IDX_W)) u_wr_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (widx_load),
    .load_val_i(host_wdata_i),
    .step_i    (data_wr),
    .idx_o     (wr_idx),
    .comp_o    (wr_comp)
  );

  cpal_seq #(.IDX_W(IDX_W)) u_rd_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (ridx_load),
    .load_val_i(host_wdata_i),
    .step_i    (data_rd),
    .idx_o     (rd_idx),
    .comp_o    (rd_comp)
  );

  // Staging for a partial triple; the entry is written on blue only.
  logic [COMP_W-1:0] red_q, grn_q;
  logic [IDX_W-1:0]  mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      red_q  <= '0;
      grn_q  <= '0;
      mask_q <= '1;
    end else begin
      if (data_wr && wr_comp == COMP_RED) red_q <= host_wdata_i[COMP_W-1:0];
      if (data_wr && wr_comp == COMP_GRN) grn_q <= host_wdata_i[COMP_W-1:0];
      if (mask_wr) mask_q <= host_wdata_i;
    end
  end

  assign commit = data_wr & (wr_comp == COMP_BLU);

  logic [ENTRY_W-1:0] host_entry, pix_entry;

  cpal_store #(.IDX_W(IDX_W), .ENTRY_W(ENTRY_W)) u_store (
    .clk_i       (clk_i),
    .we_i        (commit),
    .waddr_i     (wr_idx),
    .wdata_i     ({red_q, grn_q, host_wdata_i[COMP_W-1:0]}),
    .host_raddr_i(rd_idx),
    .host_rdata_o(host_entry),
    .pix_raddr_i (pix_idx_i & mask_q),
    .pix_rdata_o (pix_entry)
  );

  logic [COMP_W-1:0] comp_slice [NUM_COMP];
  for (genvar c = 0; c < NUM_COMP; c++) begin : g_slice
    assign comp_slice[c] = host_entry[ENTRY_W-1-c*COMP_W -: COMP_W];
  end

  logic [COMP_W-1:0] rd_comp_val;
  always_comb begin
    unique case (rd_comp)
      COMP_RED: rd_comp_val = comp_slice[0];
      COMP_GRN: rd_comp_val = comp_slice[1];
      default:  rd_comp_val = comp_slice[2];
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      host_rdata_o <= '0;
      pix_color_o  <= '0;
    end else begin
      pix_color_o <= pix_entry;
      if (rd_strobe) begin
        unique case (reg_sel)
          REG_WIDX: host_rdata_o <= wr_idx;
          REG_RIDX: host_rdata_o <= rd_idx;
          REG_DATA: host_rdata_o <= {{PAD_W{1'b0}}, rd_comp_val};
          default:  host_rdata_o <= mask_q;
        endcase
      end
    end
  end
endmodule

// File: rtl/cpal_chk.sv
module cpal_chk #(
  parameter int unsigned BUS_W   = 8,
  parameter int unsigned COMP_W  = 6,
  parameter int unsigned ENTRY_W = 18
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               host_we_i,
  input logic               host_re_i,
  input logic [1:0]         host_addr_i,
  input logic [BUS_W-1:0]   host_wdata_i,
  input logic [BUS_W-1:0]   host_rdata_o,
  input logic [BUS_W-1:0]   pix_idx_i,
  input logic [ENTRY_W-1:0] pix_color_o,
  input logic [BUS_W-1:0]   wr_idx,
  input logic [1:0]         wr_comp,
  input logic [BUS_W-1:0]   rd_idx,
  input logic [1:0]         rd_comp,
  input logic [BUS_W-1:0]   mask_q,
  input logic               commit
);
  logic [1:0] live_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) live_q <= '0;
    else if (live_q != 2'd3) live_q <= live_q + 1'b1;
  end

  // R2
  widx_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_we_i && host_addr_i == 2'd0) |=> (wr_idx == $past(host_wdata_i) && wr_comp == 2'd0));

  // R5
  widx_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_we_i && host_addr_i == 2'd2 && wr_comp == 2'd2) |=>
      (wr_idx == $past(wr_idx) + 1'b1 && wr_comp == 2'd0));

  // R6
  ridx_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_we_i && host_addr_i == 2'd1) |=> (rd_idx == $past(host_wdata_i) && rd_comp == 2'd0));

  // R7
  ridx_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_re_i && !host_we_i && host_addr_i == 2'd2 && rd_comp == 2'd2) |=>
      (rd_idx == $past(rd_idx) + 1'b1 && rd_comp == 2'd0));

  // R4
  pad_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_re_i && !host_we_i && host_addr_i == 2'd2) |=> (host_rdata_o[BUS_W-1:COMP_W] == '0));

  // R9
  pix_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_q == 2'd3 && $stable(pix_idx_i) && $stable(mask_q) && !$past(commit)) |=>
      $stable(pix_color_o));
endmodule

bind color_palette_port cpal_chk #(
  .BUS_W  (BUS_W),
  .COMP_W (COMP_W),
  .ENTRY_W(ENTRY_W)
) u_cpal_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .host_we_i   (host_we_i),
  .host_re_i   (host_re_i),
  .host_addr_i (host_addr_i),
  .host_wdata_i(host_wdata_i),
  .host_rdata_o(host_rdata_o),
  .pix_idx_i   (pix_idx_i),
  .pix_color_o (pix_color_o),
  .wr_idx      (wr_idx),
  .wr_comp     (wr_comp),
  .rd_idx      (rd_idx),
  .rd_comp     (rd_comp),
  .mask_q      (mask_q),
  .commit      (commit)
);

// File: tb/color_palette_port_tb_top.sv
`timescale 1ns/1ps
module color_palette_port_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b1;
  logic        host_we_i = 1'b0;
  logic        host_re_i = 1'b0;
  logic [1:0]  host_addr_i = 2'd0;
  logic [7:0]  host_wdata_i = 8'd0;
  logic [7:0]  host_rdata_o;
  logic [7:0]  pix_idx_i = 8'd0;
  logic [17:0] pix_color_o;

  int checks = 0;
  int errors = 0;
  logic [17:0] exp_mem [256];

  always #2.5 clk_i = ~clk_i;

  color_palette_port dut_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .host_we_i   (host_we_i),
    .host_re_i   (host_re_i),
    .host_addr_i (host_addr_i),
    .host_wdata_i(host_wdata_i),
    .host_rdata_o(host_rdata_o),
    .pix_idx_i   (pix_idx_i),
    .pix_color_o (pix_color_o)
  );

  function automatic logic [7:0] red_of(int i);  return 8'((i * 7 + 3) & 255); endfunction
  function automatic logic [7:0] grn_of(int i);  return 8'(i) ^ 8'hA5; endfunction
  function automatic logic [7:0] blu_of(int i);  return 8'(255 - i); endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic host_wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk_i);
    host_we_i = 1'b1; host_addr_i = a; host_wdata_i = d;
    @(negedge clk_i);
    host_we_i = 1'b0;
  endtask

  task automatic host_rd(logic [1:0] a, output logic [7:0] d);
    @(negedge clk_i);
    host_re_i = 1'b1; host_addr_i = a;
    @(negedge clk_i);
    host_re_i = 1'b0;
    d = host_rdata_o;
  endtask

  task automatic pix_look(logic [7:0] idx, output logic [17:0] c);
    @(negedge clk_i);
    pix_idx_i = idx;
    @(negedge clk_i);
    c = pix_color_o;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0]  d;
    logic [17:0] c;
    logic [7:0]  m;
    #1 rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 reset state
    host_rd(2'd0, d); check("R1 widx reset", d, 8'h00);
    host_rd(2'd1, d); check("R1 ridx reset", d, 8'h00);
    host_rd(2'd3, d); check("R1 mask reset", d, 8'hFF);

    // R3 R4 R5: full write sweep with junk in bits 7:6
    host_wr(2'd0, 8'd0);
    for (int i = 0; i < 256; i++) begin
      host_wr(2'd2, red_of(i));
      host_wr(2'd2, grn_of(i));
      host_wr(2'd2, blu_of(i));
      exp_mem[i] = {red_of(i)[5:0], grn_of(i)[5:0], blu_of(i)[5:0]};
      if (i == 9)   begin host_rd(2'd0, d); check("R5 widx after 10", d, 8'd10); end
      if (i == 254) begin host_rd(2'd0, d); check("R5 widx after 255", d, 8'd255); end
    end
    host_rd(2'd0, d); check("R5 widx wrap", d, 8'd0);

    // R7 R4: full readback sweep
    host_wr(2'd1, 8'd0);
    for (int i = 0; i < 256; i++) begin
      host_rd(2'd2, d); check("R7 R4 red", d, {2'b00, exp_mem[i][17:12]});
      host_rd(2'd2, d); check("R7 R4 green", d, {2'b00, exp_mem[i][11:6]});
      host_rd(2'd2, d); check("R7 R4 blue", d, {2'b00, exp_mem[i][5:0]});
      if (i == 99) begin host_rd(2'd1, d); check("R7 ridx after 100", d, 8'd100); end
    end
    host_rd(2'd1, d); check("R7 ridx wrap", d, 8'd0);

    // R8 R9: pixel sweeps under several masks
    for (int mi = 0; mi < 3; mi++) begin
      m = (mi == 0) ? 8'hFF : (mi == 1) ? 8'h0F : 8'hA5;
      host_wr(2'd3, m);
      host_rd(2'd3, d); check("R8 mask readback", d, m);
      for (int i = 0; i < 256; i++) begin
        pix_look(8'(i), c);
        check("R8 R9 pixel lookup", c, exp_mem[8'(i) & m]);
      end
    end
    host_wr(2'd3, 8'hFF);

    // R2: index write discards a partial triple
    host_wr(2'd0, 8'd5);
    host_wr(2'd2, 8'h3F);
    host_wr(2'd0, 8'd7);
    host_wr(2'd2, 8'h11); host_wr(2'd2, 8'h22); host_wr(2'd2, 8'h33);
    exp_mem[7] = {6'h11, 6'h22, 6'h33};
    pix_look(8'd7, c); check("R2 new start entry", c, exp_mem[7]);
    pix_look(8'd5, c); check("R2 abandoned entry intact", c, exp_mem[5]);
    host_rd(2'd0, d); check("R2 widx after triple", d, 8'd8);

    // R3: commit only on blue
    host_wr(2'd0, 8'd9);
    host_wr(2'd2, 8'hC1); host_wr(2'd2, 8'h02);
    pix_look(8'd9, c); check("R3 no commit before blue", c, exp_mem[9]);
    host_wr(2'd2, 8'h7F);
    exp_mem[9] = {6'h01, 6'h02, 6'h3F};
    pix_look(8'd9, c); check("R3 commit on blue", c, exp_mem[9]);

    // R9: same-cycle blue write and pixel lookup of that entry
    host_wr(2'd0, 8'd20);
    host_wr(2'd2, 8'h15); host_wr(2'd2, 8'h2A);
    @(negedge clk_i);
    host_we_i = 1'b1; host_addr_i = 2'd2; host_wdata_i = 8'h0C; pix_idx_i = 8'd20;
    @(negedge clk_i);
    host_we_i = 1'b0;
    check("R9 collision old value", pix_color_o, exp_mem[20]);
    exp_mem[20] = {6'h15, 6'h2A, 6'h0C};
    @(negedge clk_i);
    check("R9 collision new value", pix_color_o, exp_mem[20]);

    // R6: read-index write restarts at red
    host_wr(2'd1, 8'd3);
    host_rd(2'd2, d); check("R6 first red", d, {2'b00, exp_mem[3][17:12]});
    host_wr(2'd1, 8'd3);
    host_rd(2'd2, d); check("R6 red after reload", d, {2'b00, exp_mem[3][17:12]});
    host_rd(2'd2, d); check("R6 green follows", d, {2'b00, exp_mem[3][11:6]});

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule